// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper with Cycle-Count Interrupt

This block sits on the cartridge side of an 8-bit CPU bus. It decodes the 16-bit CPU address into a byte address for an external program ROM. It does this through three windows. The top 32 KiB of CPU space shows one of two switchable 32 KiB ROM banks. A 4 KiB window and an 8 KiB window below it are tied permanently to two fixed ROM banks. A small range of I/O addresses reads back as all ones. Other reads are left to the open bus. A flag tells the system whether the block drives the data bus on the current read.

The block also holds a free-running cycle counter for timed interrupts. Software writes a control register to choose whether the counter runs, and every such write restarts the count from zero. Once the counter has seen the threshold number of enabled CPU cycles, the interrupt line goes high. It stays high until the next control write. The ROM address and the drive flag are combinational, so the ROM sees its address in the same cycle as the CPU. The register state and the interrupt change only on clock edges.

Top module: `prg_bank_mapper`

## Requirements
- R1: A read at $8000–$FFFF drives `rom_addr` = (bank × 0x8000) + address bits 14:0. The bank is bit 0 of the data in the last write to $4022, and data bits 7:1 are ignored, so 0xFE selects bank 0 and 0xFF selects bank 1.
- R2: A read at $5000–$5FFF drives `rom_addr` = 0x11000 + address bits 11:0, whatever the bank select holds.
- R3: A read at $6000–$7FFF drives `rom_addr` = 0x12000 + address bits 12:0, whatever the bank select holds.
- R4: `rom_addr` keeps only the low `ROM_ADDR_W` bits of the computed offset, so with a 64 KiB ROM (`ROM_ADDR_W` = 16) address $5000 maps to 0x01000 and $6000 maps to 0x02000.
- R5: `bus_drive` is 1 only when `cpu_rw` = 1 (read) and the address lies in $4042–$4055 or in one of the three ROM windows. In $4042–$4055 `forced_data` is 0xFF. Reads at $4041, $4056 and $4000, and every write, leave `bus_drive` at 0.
- R6: A register write happens only at a clock edge where `cpu_cycle_en` = 1, `cpu_rw` = 0 and the address equals $4022 or $4122 exactly. A write to a neighbouring address such as $4023 or $4522, or any write with `cpu_cycle_en` = 0, changes nothing.
- R7: A write to $4122 loads the counter enable from data bit 0 and sets the counter to 0, so `irq_out` is low from the next cycle on. This write takes priority over a count in the same cycle.
- R8: While enabled, the counter adds one at every edge with `cpu_cycle_en` = 1 and wraps at 2^CNT_W. It holds its value on other edges. `irq_out` is 1 exactly when the counter is enabled and its value is at least 4096. It is therefore low after 4095 counted cycles and high after 4096, and it stays high as the count grows.
- R9: Data bits 7:1 of a $4122 write are ignored, so writing 0xFE leaves the counter disabled and `irq_out` low for any number of cycles.
- R10: A clock edge with `rst_n` = 0 sets the bank select to 0, disables the counter and clears it to 0, so that $8000 then maps to ROM address 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data |
| cpu_cycle_en | input | 1 | High for one clock per CPU cycle; qualifies writes and counting |
| rom_addr | output | ROM_ADDR_W | Program ROM byte address |
| bus_drive | output | 1 | High when the block drives the CPU data bus |
| forced_data | output | 8 | Value to drive for the I/O read range |
| irq_out | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions check the following on every cycle:
- a bank write loads the select, and nothing else moves it;
- the drive flag is never raised for a write;
- the I/O range always yields 0xFF;
- a control write clears the count and the interrupt;
- the counter either steps by exactly one or holds still;
- the interrupt rises only as the count passes 4095.

The bench scenarios show the rest:
- the concrete ROM addresses at each window edge;
- the wrap on a smaller ROM;
- the open-bus boundaries at $4041 and $4056;
- the exact 4095/4096 threshold;
- the disabled counter after a 0xFE write;
- the write that wins over a running count.

// File: rtl/mapper_pkg.sv
// Package: types shared by the mapper blocks.
// Assumes: one window code per CPU address; the codes never overlap.
package mapper_pkg;

    typedef enum logic [2:0] {
        WIN_NONE  = 3'd0,
        WIN_IO    = 3'd1,
        WIN_FIX4K = 3'd2,
        WIN_FIX8K = 3'd3,
        WIN_SWAP  = 3'd4
    } win_e;

endpackage

// File: rtl/mapper_win_decode.sv
// Module: sorts a CPU address into one of the mapper windows.
// Assumes: the three ROM windows sit at fixed CPU addresses ($5000, $6000,
// $8000); only the forced-read I/O range is set by parameters.
module mapper_win_decode
    import mapper_pkg::*;
#(
    parameter logic [15:0] IO_LO = 16'h4042,
    parameter logic [15:0] IO_HI = 16'h4055
) (
    input  logic [15:0] addr,
    output win_e        win
);

    // Priority decode; the windows do not overlap, so the order only sets depth.
    always_comb begin
        if (addr[15])
            win = WIN_SWAP;
        else if (addr[15:13] == 3'b011)
            win = WIN_FIX8K;
        else if (addr[15:12] == 4'h5)
            win = WIN_FIX4K;
        else if (addr >= IO_LO && addr <= IO_HI)
            win = WIN_IO;
        else
            win = WIN_NONE;
    end

endmodule

// File: rtl/mapper_rom_xlate.sv
// Module: turns a window code and CPU offset into a ROM byte address.
// Assumes: ROM size is a power of two (2^ROM_ADDR_W); offsets past it wrap.
module mapper_rom_xlate
    import mapper_pkg::*;
#(
    parameter int ROM_ADDR_W = 17,
    parameter int BANK_W     = 1,
    parameter int FIX4K_BANK = 17,
    parameter int FIX8K_BANK = 9
) (
    input  win_e                  win,
    input  logic [14:0]           offs,
    input  logic [BANK_W-1:0]     bank,
    output logic [ROM_ADDR_W-1:0] rom_addr
);

    localparam int SWAP_SHIFT = 15;
    localparam logic [ROM_ADDR_W-1:0] BASE4K = ROM_ADDR_W'(FIX4K_BANK * 4096);
    localparam logic [ROM_ADDR_W-1:0] BASE8K = ROM_ADDR_W'(FIX8K_BANK * 8192);

    // Select the window base and add the in-window offset, truncating to ROM size.
    always_comb begin
        unique case (win)
            WIN_SWAP:  rom_addr = ROM_ADDR_W'({bank, offs[SWAP_SHIFT-1:0]});
            WIN_FIX4K: rom_addr = BASE4K + ROM_ADDR_W'(offs[11:0]);
            WIN_FIX8K: rom_addr = BASE8K + ROM_ADDR_W'(offs[12:0]);
            default:   rom_addr = '0;
        endcase
    end

endmodule

// File: rtl/mapper_cycle_timer.sv
// Module: CPU-cycle counter with a level interrupt at a threshold.
// Assumes: tick is high for one clock per CPU cycle; a control write
// always lands on a tick and takes priority over the count.
module mapper_cycle_timer #(
    parameter int CNT_W     = 32,
    parameter int IRQ_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_en,
    output logic             irq
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IRQ_LIMIT);

    // Enable flag: loaded by each control write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_en <= 1'b0;
        else if (ctrl_wr)
            cnt_en <= ctrl_en;
    end

    // Counter: restart on a control write, else step on enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ctrl_wr)
            cnt <= '0;
        else if (cnt_en && tick)
            cnt <= cnt + 1'b1;
    end

    // Interrupt level from the registered state.
    assign irq = cnt_en && (cnt >= LIMIT);

endmodule

// File: rtl/prg_bank_mapper.sv
// Module: cartridge PRG mapper top. It decodes the CPU address into ROM
// windows, holds the 32 KiB bank select and owns the cycle interrupt timer.
// Assumes: cpu_rw and cpu_addr are stable during the clock with
// cpu_cycle_en high; reads need no enable because they hold no state.
module prg_bank_mapper
    import mapper_pkg::*;
#(
    parameter int          ROM_ADDR_W = 17,
    parameter int          BANK_W     = 1,
    parameter int          CNT_W      = 32,
    parameter int          IRQ_LIMIT  = 4096,
    parameter int          FIX4K_BANK = 17,
    parameter int          FIX8K_BANK = 9,
    parameter logic [15:0] BANK_ADDR  = 16'h4022,
    parameter logic [15:0] CTRL_ADDR  = 16'h4122,
    parameter logic [15:0] IO_LO      = 16'h4042,
    parameter logic [15:0] IO_HI      = 16'h4055
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic                  cpu_rw,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_cycle_en,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic                  bus_drive,
    output logic [7:0]            forced_data,
    output logic                  irq_out
);

    win_e              win;
    logic              wr_cycle;
    logic              bank_wr;
    logic              ctrl_wr;
    logic [BANK_W-1:0] bank_q;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_en;
    logic              wdata_unused;

    // Upper data bits carry no state.
    assign wdata_unused = ^cpu_wdata;

    // Register strobes: full 16-bit match on a qualified write cycle.
    assign wr_cycle = cpu_cycle_en && !cpu_rw;
    assign bank_wr  = wr_cycle && (cpu_addr == BANK_ADDR);
    assign ctrl_wr  = wr_cycle && (cpu_addr == CTRL_ADDR);

    // Bank select register for the switchable 32 KiB window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (bank_wr)
            bank_q <= cpu_wdata[BANK_W-1:0];
    end

    mapper_win_decode #(
        .IO_LO (IO_LO),
        .IO_HI (IO_HI)
    ) u_decode (
        .addr (cpu_addr),
        .win  (win)
    );

    mapper_rom_xlate #(
        .ROM_ADDR_W (ROM_ADDR_W),
        .BANK_W     (BANK_W),
        .FIX4K_BANK (FIX4K_BANK),
        .FIX8K_BANK (FIX8K_BANK)
    ) u_xlate (
        .win      (win),
        .offs     (cpu_addr[14:0]),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    mapper_cycle_timer #(
        .CNT_W     (CNT_W),
        .IRQ_LIMIT (IRQ_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cpu_cycle_en),
        .ctrl_wr (ctrl_wr),
        .ctrl_en (cpu_wdata[0]),
        .cnt     (cnt),
        .cnt_en  (cnt_en),
        .irq     (irq_out)
    );

    // Bus drive: any read that lands in a decoded window.
    assign bus_drive   = cpu_rw && (win != WIN_NONE);
    assign forced_data = (win == WIN_IO) ? 8'hFF : 8'h00;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
// Module: assertion checker for prg_bank_mapper, attached by bind.
// Assumes: it sees the top's ports plus the bank, count and enable state.
module prg_bank_mapper_chk #(
    parameter int          BANK_W    = 1,
    parameter int          CNT_W     = 32,
    parameter int          IRQ_LIMIT = 4096,
    parameter logic [15:0] BANK_ADDR = 16'h4022,
    parameter logic [15:0] CTRL_ADDR = 16'h4122,
    parameter logic [15:0] IO_LO     = 16'h4042,
    parameter logic [15:0] IO_HI     = 16'h4055
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_cycle_en,
    input logic              wr_bit,
    input logic [BANK_W-1:0] wr_bank,
    input logic              bus_drive,
    input logic [7:0]        forced_data,
    input logic              irq_out,
    input logic [BANK_W-1:0] bank_q,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_en
);

    logic bank_w, ctrl_w, io_rd;
    assign bank_w = cpu_cycle_en && !cpu_rw && (cpu_addr == BANK_ADDR);
    assign ctrl_w = cpu_cycle_en && !cpu_rw && (cpu_addr == CTRL_ADDR);
    assign io_rd  = cpu_rw && (cpu_addr >= IO_LO) && (cpu_addr <= IO_HI);

    p_bank_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bank_w |=> bank_q == $past(wr_bank));

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_w |=> $stable(bank_q));

    p_drive_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> cpu_rw);

    p_io_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |-> (bus_drive && forced_data == 8'hFF));

    p_ctrl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w |=> (cnt == '0 && !irq_out && cnt_en == $past(wr_bit)));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_w && cnt_en && cpu_cycle_en) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_w && !(cnt_en && cpu_cycle_en)) |=> ($stable(cnt) && $stable(cnt_en)));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(cnt) == CNT_W'(IRQ_LIMIT - 1));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (bank_q == '0 && cnt == '0 && !cnt_en && !irq_out));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
    .BANK_W    (BANK_W),
    .CNT_W     (CNT_W),
    .IRQ_LIMIT (IRQ_LIMIT),
    .BANK_ADDR (BANK_ADDR),
    .CTRL_ADDR (CTRL_ADDR),
    .IO_LO     (IO_LO),
    .IO_HI     (IO_HI)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rw       (cpu_rw),
    .cpu_cycle_en (cpu_cycle_en),
    .wr_bit       (cpu_wdata[0]),
    .wr_bank      (cpu_wdata[BANK_W-1:0]),
    .bus_drive    (bus_drive),
    .forced_data  (forced_data),
    .irq_out      (irq_out),
    .bank_q       (bank_q),
    .cnt          (cnt),
    .cnt_en       (cnt_en)
);

// File: tb/prg_bank_mapper_tb.sv
// Directed bench for prg_bank_mapper: one task per scenario.
module prg_bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_cycle_en = 1'b0;
    logic [16:0] rom_addr;
    logic        bus_drive;
    logic [7:0]  forced_data;
    logic        irq_out;
    logic [15:0] rom_addr_s;
    logic        bus_drive_s;
    logic [7:0]  forced_data_s;
    logic        irq_out_s;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    prg_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .cpu_cycle_en(cpu_cycle_en), .rom_addr(rom_addr),
        .bus_drive(bus_drive), .forced_data(forced_data), .irq_out(irq_out)
    );

    prg_bank_mapper #(.ROM_ADDR_W(16)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .cpu_cycle_en(cpu_cycle_en), .rom_addr(rom_addr_s),
        .bus_drive(bus_drive_s), .forced_data(forced_data_s), .irq_out(irq_out_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input bit en);
        cpu_addr = a; cpu_rw = 1'b0; cpu_wdata = d; cpu_cycle_en = en;
        @(negedge clk);
        cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_cycle_en = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        cpu_addr = 16'h0000; cpu_rw = 1'b1; cpu_cycle_en = 1'b1;
        repeat (n) @(negedge clk);
        cpu_cycle_en = 1'b0;
    endtask

    task automatic expect_read(input string req, input logic [15:0] a,
                               input logic drv, input logic [16:0] ra);
        cpu_addr = a; cpu_rw = 1'b1; cpu_cycle_en = 1'b0;
        #5;
        check({req, " drive"}, 32'(bus_drive), 32'(drv));
        if (drv) check({req, " rom_addr"}, 32'(rom_addr), 32'(ra));
        @(negedge clk);
    endtask

    task automatic expect_irq(input string req, input logic exp);
        #2;
        check(req, 32'(irq_out), 32'(exp));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_read("R10 bank 0 after reset", 16'h8000, 1'b1, 17'h00000);
        expect_irq("R10 irq low after reset", 1'b0);
    endtask

    task automatic t_bank;
        cpu_write(16'h4022, 8'h01, 1'b1);
        expect_read("R1 bank1 $8000", 16'h8000, 1'b1, 17'h08000);
        expect_read("R1 bank1 $FFFF", 16'hFFFF, 1'b1, 17'h0FFFF);
        cpu_write(16'h4022, 8'hFE, 1'b1);
        expect_read("R1 0xFE picks bank0", 16'hC123, 1'b1, 17'h04123);
        cpu_write(16'h4022, 8'hFF, 1'b1);
        expect_read("R1 0xFF picks bank1", 16'h8000, 1'b1, 17'h08000);
    endtask

    task automatic t_fixed;
        expect_read("R2 $5000", 16'h5000, 1'b1, 17'h11000);
        expect_read("R2 $5FFF", 16'h5FFF, 1'b1, 17'h11FFF);
        expect_read("R3 $6000", 16'h6000, 1'b1, 17'h12000);
        expect_read("R3 $7FFF", 16'h7FFF, 1'b1, 17'h13FFF);
        cpu_write(16'h4022, 8'h00, 1'b1);
        expect_read("R2 $5000 bank0", 16'h5000, 1'b1, 17'h11000);
        expect_read("R3 $6000 bank0", 16'h6000, 1'b1, 17'h12000);
    endtask

    task automatic t_wrap;
        cpu_addr = 16'h5000; cpu_rw = 1'b1; #5;
        check("R4 small $5000", 32'(rom_addr_s), 32'h1000);
        @(negedge clk);
        cpu_addr = 16'h7FFF; #5;
        check("R4 small $7FFF", 32'(rom_addr_s), 32'h3FFF);
        @(negedge clk);
    endtask

    task automatic t_io;
        cpu_addr = 16'h4042; cpu_rw = 1'b1; #5;
        check("R5 $4042 drive", 32'(bus_drive), 32'd1);
        check("R5 $4042 data", 32'(forced_data), 32'hFF);
        @(negedge clk);
        cpu_addr = 16'h4050; #5;
        check("R5 $4050 data", 32'(forced_data), 32'hFF);
        @(negedge clk);
        cpu_addr = 16'h4055; #5;
        check("R5 $4055 drive", 32'(bus_drive), 32'd1);
        check("R5 $4055 data", 32'(forced_data), 32'hFF);
        @(negedge clk);
        expect_read("R5 $4041 open", 16'h4041, 1'b0, '0);
        expect_read("R5 $4056 open", 16'h4056, 1'b0, '0);
        expect_read("R5 $4000 open", 16'h4000, 1'b0, '0);
        cpu_addr = 16'h8000; cpu_rw = 1'b0; #5;
        check("R5 write not driven", 32'(bus_drive), 32'd0);
        cpu_rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_decode;
        cpu_write(16'h4022, 8'h01, 1'b1);
        cpu_write(16'h4023, 8'h00, 1'b1);
        expect_read("R6 $4023 ignored", 16'h8000, 1'b1, 17'h08000);
        cpu_write(16'h4022, 8'h00, 1'b0);
        expect_read("R6 no-enable write ignored", 16'h8000, 1'b1, 17'h08000);
        cpu_write(16'h4522, 8'h01, 1'b1);
        run_cycles(4200);
        expect_irq("R6 $4522 ignored", 1'b0);
        cpu_write(16'h4022, 8'h00, 1'b1);
    endtask

    task automatic t_irq;
        cpu_write(16'h4122, 8'h01, 1'b1);
        run_cycles(4095);
        expect_irq("R8 low after 4095", 1'b0);
        cpu_cycle_en = 1'b0;
        repeat (50) @(negedge clk);
        expect_irq("R8 hold without tick", 1'b0);
        run_cycles(1);
        expect_irq("R8 high after 4096", 1'b1);
        run_cycles(300);
        expect_irq("R8 stays high", 1'b1);
        cpu_write(16'h4122, 8'h01, 1'b1);
        expect_irq("R7 write clears irq", 1'b0);
        run_cycles(4095);
        expect_irq("R7 restart low at 4095", 1'b0);
        run_cycles(1);
        expect_irq("R7 restart high at 4096", 1'b1);
        cpu_write(16'h4122, 8'h00, 1'b1);
        run_cycles(5000);
        expect_irq("R7 disabled stays low", 1'b0);
    endtask

    task automatic t_upper_bits;
        cpu_write(16'h4122, 8'hFE, 1'b1);
        run_cycles(5000);
        expect_irq("R9 0xFE leaves disabled", 1'b0);
    endtask

    task automatic t_reset_mid;
        cpu_write(16'h4022, 8'h01, 1'b1);
        cpu_write(16'h4122, 8'h01, 1'b1);
        run_cycles(4096);
        expect_irq("R8 high before reset", 1'b1);
        t_reset;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_bank;
        t_fixed;
        t_wrap;
        t_io;
        t_decode;
        t_irq;
        t_upper_bits;
        t_reset_mid;
        summary;
        $finish;
    end

endmodule